// File: doc/BRIEF.md
# Adjacency Short Locator

This block finds which pairs of neighbouring nets in an interconnect are bridged together. It keeps one status bit for every unordered pair of nets that the layout makes adjacent. A start strobe loads the adjacency graph and marks every present pair as suspect. Each captured response vector then arrives on the response port, one per cycle. For every suspect pair, the engine compares the two nets' response bits. If they differ, the pair cannot be bridged and is dropped for the rest of the run.

Bridges are taken to behave as wired-OR, so bridged nets always read alike and their pair is never dropped. When the finish strobe arrives, every pair still suspect is reported. The report is a symmetric N×N matrix together with the number of located shorts. All pair comparisons run in parallel, so the block accepts one response vector per clock.

Top module: `short_locator`

## Requirements
- R1: After reset, `done_o` is low, `short_mat_o` is all zero and `short_cnt_o` is zero.
- R2: On `start_i`, the pair (i,j), i≠j, becomes suspect when bit i*N+j or bit j*N+i of `adj_i` is set. Diagonal bits of `adj_i` are ignored, and `short_mat_o` and `short_cnt_o` are cleared.
- R3: A response vector accepted during a run drops every suspect pair whose two bits differ, with either net at 1 and the other at 0. Bit k of `resp_i` is net k.
- R4: A dropped pair stays dropped until the next start. A response with all bits equal (all 0 or all 1) drops nothing.
- R5: One cycle after `finish_i` is accepted in a run, `done_o` is high for exactly one cycle. At that point `short_mat_o` holds the surviving pairs at both bit i*N+j and bit j*N+i. `short_cnt_o` holds the number of surviving unordered pairs. A response presented in the same cycle as `finish_i` is applied before the report.
- R6: The reported matrix and count hold their values until the next accepted finish or start.
- R7: While no run is open (before a start or after a finish), `resp_valid_i` and `finish_i` have no effect. Outputs stay unchanged and `done_o` stays low.
- R8: `start_i` takes priority over `resp_valid_i` and `finish_i` in the same cycle. A start during a run reloads the graph.
- R9: On a chain of 7 nets with wired-OR bridges on the pairs (1,2) and (4,5), zero-based, walking-one responses leave exactly those two pairs, and the count is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load adjacency and open a run |
| adj_i | input | N*N | Adjacency matrix, bit i*N+j for pair (i,j) |
| resp_valid_i | input | 1 | Response vector present |
| resp_i | input | N | Observed response, bit k for net k |
| finish_i | input | 1 | Close the run and report |
| done_o | output | 1 | One-cycle report strobe |
| short_mat_o | output | N*N | Symmetric located-short matrix |
| short_cnt_o | output | $clog2(N*(N-1)/2+1) | Number of located shorts |

## Verification
Start and response strobes act on internal state at the edge that samples them, with no latency of their own. Their effect shows only at the report, which is registered once. So `done_o`, `short_mat_o` and `short_cnt_o` are due exactly one edge after the finish strobe. The bench drives inputs on the falling edge and checks the report at the next falling edge. It checks `done_o` low again one cycle later. The idle-input and held-output cases are checked by comparing the same outputs at falling edges after the ignored strobes.

// File: rtl/short_locator.sv
module short_locator #(
  parameter int N = 8,
  localparam int M = N * N,
  localparam int EMAX = N * (N - 1) / 2,
  localparam int CW = $clog2(EMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [M-1:0]  adj_i,
  input  logic          resp_valid_i,
  input  logic [N-1:0]  resp_i,
  input  logic          finish_i,
  output logic          done_o,
  output logic [M-1:0]  short_mat_o,
  output logic [CW-1:0] short_cnt_o
);

  logic          run_q;
  logic [M-1:0]  sus_q, sus_nx, load_v, mir_v;
  logic [CW-1:0] pop_v;

  always_comb begin
    load_v = '0;
    sus_nx = sus_q;
    mir_v  = '0;
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++) begin
        load_v[i*N+j] = adj_i[i*N+j] | adj_i[j*N+i];
        if (resp_valid_i && (resp_i[i] != resp_i[j]))
          sus_nx[i*N+j] = 1'b0;
        mir_v[i*N+j] = sus_nx[i*N+j];
        mir_v[j*N+i] = sus_nx[i*N+j];
      end
  end

  always_comb begin
    pop_v = '0;
    for (int k = 0; k < M; k++)
      pop_v = pop_v + CW'(sus_nx[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      sus_q       <= '0;
      done_o      <= 1'b0;
      short_mat_o <= '0;
      short_cnt_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        run_q       <= 1'b1;
        sus_q       <= load_v;
        short_mat_o <= '0;
        short_cnt_o <= '0;
      end else if (run_q) begin
        sus_q <= sus_nx;
        if (finish_i) begin
          run_q       <= 1'b0;
          done_o      <= 1'b1;
          short_mat_o <= mir_v;
          short_cnt_o <= pop_v;
        end
      end
    end
  end

  a_r4_no_revive: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ((sus_q & ~$past(sus_q)) == '0));

  a_r4_equal_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && (!resp_valid_i || resp_i == '0 || resp_i == '1)) |=> $stable(sus_q));

  a_r7_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start_i) |=> ($stable(sus_q) && !done_o));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r6_report_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !(run_q && finish_i)) |=> ($stable(short_mat_o) && $stable(short_cnt_o)));

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (int'(short_cnt_o) <= EMAX));

endmodule

// File: tb/short_locator_test.sv
module short_locator_test;
  localparam int N = 8;
  localparam int M = N * N;
  localparam int CW = $clog2(N * (N - 1) / 2 + 1);

  logic clk = 0, rst_n = 0, start_i = 0, resp_valid_i = 0, finish_i = 0;
  logic [M-1:0] adj_i = '0;
  logic [N-1:0] resp_i = '0;
  logic done_o;
  logic [M-1:0] short_mat_o;
  logic [CW-1:0] short_cnt_o;

  int checks = 0, errors = 0;
  bit m_run = 0, ended = 0;
  logic [M-1:0] m_e = '0;

  always #4 clk = ~clk;

  short_locator #(.N(N)) uut (.*);

  function automatic logic [M-1:0] mirror(input logic [M-1:0] e);
    logic [M-1:0] r = '0;
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++) begin
        r[i*N+j] = e[i*N+j];
        r[j*N+i] = e[i*N+j];
      end
    return r;
  endfunction

  function automatic int npairs(input logic [M-1:0] e);
    int c = 0;
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++) c += int'(e[i*N+j]);
    return c;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [M-1:0] act, input logic [M-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic m_apply(input logic [N-1:0] v);
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        if (v[i] != v[j]) m_e[i*N+j] = 1'b0;
  endtask

  task automatic do_start(input logic [M-1:0] a);
    start_i = 1; adj_i = a;
    @(negedge clk);
    start_i = 0;
    m_run = 1; m_e = '0;
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++) m_e[i*N+j] = a[i*N+j] | a[j*N+i];
  endtask

  task automatic do_resp(input logic [N-1:0] v);
    resp_valid_i = 1; resp_i = v;
    @(negedge clk);
    resp_valid_i = 0;
    if (m_run) m_apply(v);
  endtask

  task automatic do_finish(input bit with_resp, input logic [N-1:0] v, input string tag);
    finish_i = 1; resp_valid_i = with_resp; resp_i = v;
    @(negedge clk);
    finish_i = 0; resp_valid_i = 0;
    if (with_resp) m_apply(v);
    m_run = 0;
    check(done_o === 1'b1, {tag, " done high"}, M'(done_o), M'(1));
    check(short_mat_o === mirror(m_e), {tag, " matrix"}, short_mat_o, mirror(m_e));
    check(int'(short_cnt_o) == npairs(m_e), {tag, " count"}, M'(short_cnt_o), M'(npairs(m_e)));
    @(negedge clk);
    check(done_o === 1'b0, "R5 done one cycle", M'(done_o), M'(0));
  endtask

  function automatic logic [M-1:0] pair(input int i, input int j);
    logic [M-1:0] r = '0;
    r[i*N+j] = 1'b1;
    return r;
  endfunction

  initial begin
    logic [M-1:0] chain, held, full;
    logic [N-1:0] w;
    repeat (2) @(negedge clk);
    check(done_o === 0 && short_mat_o === '0 && short_cnt_o === '0, "R1 reset state", short_mat_o, '0);
    rst_n = 1;
    @(negedge clk);

    // R9: 7-net chain, wired-OR bridges on (1,2) and (4,5)
    chain = '0;
    for (int i = 0; i < 6; i++) chain |= pair(i, i + 1);
    do_start(chain);
    for (int k = 0; k < 7; k++) begin
      w = N'(1) << k;
      if (w[1] | w[2]) w[2:1] = 2'b11;
      if (w[4] | w[5]) w[5:4] = 2'b11;
      do_resp(w);
    end
    do_finish(0, '0, "R9 chain");
    check(short_mat_o === mirror(pair(1, 2) | pair(4, 5)) && short_cnt_o == 2, "R9 exact pairs",
          short_mat_o, mirror(pair(1, 2) | pair(4, 5)));

    // R6/R7: idle strobes change nothing
    held = short_mat_o;
    do_resp(8'h0F);
    finish_i = 1; @(negedge clk); finish_i = 0;
    check(done_o === 0, "R7 idle finish no done", M'(done_o), M'(0));
    @(negedge clk);
    check(short_mat_o === held && short_cnt_o == 2, "R6 R7 report held", short_mat_o, held);

    // R2: full graph through lower-triangle bits and diagonal; max count
    full = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j <= i; j++) full[i*N+j] = 1'b1;
    do_start(full);
    check(short_mat_o === '0 && short_cnt_o == 0, "R2 start clears report", short_mat_o, '0);
    do_resp('0);
    do_resp('1);
    do_finish(0, '0, "R4 equal responses");
    check(short_cnt_o == 28, "R2 R4 full count", M'(short_cnt_o), M'(28));

    // R3/R5: response together with finish, both polarities
    do_start(full);
    do_resp(8'b0000_0001);
    do_finish(1, 8'b1111_1110, "R3 R5 same-cycle resp");

    // R8: start wins over finish, restart mid-run
    do_start(full);
    do_resp(8'hAA);
    start_i = 1; finish_i = 1; adj_i = pair(0, 7);
    @(negedge clk);
    start_i = 0; finish_i = 0;
    m_e = pair(0, 7); m_run = 1;
    check(done_o === 0, "R8 start beats finish", M'(done_o), M'(0));
    do_finish(0, '0, "R8 restart");

    // R3/R4: sweep with random graphs and vectors
    for (int t = 0; t < 60; t++) begin
      logic [M-1:0] a;
      a = {$urandom, $urandom};
      do_start(a);
      for (int k = 0; k < (t % 5); k++) do_resp(N'($urandom));
      do_finish(t[0], N'($urandom), "R3 R4 sweep");
    end

    ended = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!ended) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule